// File: doc/BRIEF.md
# Privileged Flag and Control Registers

This block keeps the two status words of a small processor core: a flag word and a control word. The flag word holds the arithmetic condition bits. The ALU loads them through an update strobe, and software can load them directly through a write port. The control word holds the interrupt-enable, user-mode and DMA-enable bits, and these three bits are also driven out as decoded outputs.

Software can change the control word only while the core is in system mode. The mode is given by the user-mode bit of the control word itself. When a control write arrives while that bit is set, the block drops the write and raises a one-cycle privilege-fault pulse. Software reads go through one combinational read port with a register select. A read shows the value held before any write in the same cycle.

Top module: `cpu_status_regs`

## Requirements
- R1: After reset both words read 0, and `irq_en`, `user_mode`, `dma_en` and `priv_fault` are all 0. The core therefore starts in system mode.
- R2: When `alu_upd` is 1 and no software flag write is present, the flag word takes `alu_flags` at the clock edge. The bit mapping is: bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 sign.
- R3: A software write with `wr_en`=1 and `wr_sel`=0 loads `wr_data[3:0]` into the flag word. This works in either mode. Flag bits 31..4 always read 0, whatever value was written to them.
- R4: When a software flag write and `alu_upd` occur in the same cycle, the flag word takes the software value.
- R5: In system mode (`user_mode`=0), a write with `wr_en`=1 and `wr_sel`=1 loads `wr_data[2:0]` into the control word. The bit mapping is: bit 0 drives `irq_en`, bit 1 drives `user_mode`, bit 2 drives `dma_en`. Control bits 31..3 always read 0.
- R6: In user mode, a control write leaves the control word unchanged. `priv_fault` is 1 for exactly the one cycle that follows the clock edge at which the write was dropped.
- R7: `rd_data` shows the flag word when `rd_sel`=0 and the control word when `rd_sel`=1. In the cycle of a write, `rd_data` still shows the value held before that write.
- R8: Flag writes and ALU updates do not change the control word. Control writes do not change the flag word.
- R9: `priv_fault` stays 0 for every cycle not covered by R6. This includes flag writes made in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_upd | input | 1 | ALU flag update strobe |
| alu_flags | input | 4 | ALU results: carry, overflow, zero, sign (bits 0..3) |
| wr_en | input | 1 | Software write enable |
| wr_sel | input | 1 | Write target: 0 selects the flag word, 1 selects the control word |
| wr_data | input | 32 | Software write data |
| rd_sel | input | 1 | Read target: 0 selects the flag word, 1 selects the control word |
| rd_data | output | 32 | Read data (combinational) |
| irq_en | output | 1 | Interrupt enable |
| user_mode | output | 1 | User mode, 1 means unprivileged |
| dma_en | output | 1 | DMA enable |
| priv_fault | output | 1 | One-cycle pulse after a dropped control write |

## Verification
Register updates and the fault pulse come out of flops. They therefore appear one clock edge after the cycle that carries the stimulus. `rd_data` is combinational, so inside the stimulus cycle it still shows the old value. The driver task sets each stimulus on a falling edge. It checks `rd_data` 1 ns later against the value held before the write, and then queues the values expected after the edge. The monitor takes those values off the queue 2 ns after the next rising edge and compares them. Every comparison therefore falls in a quiet window between edges.

// File: rtl/cpu_status_regs.sv
module cpu_status_regs #(
  parameter int XLEN      = 32,
  parameter int FLAG_BITS = 4,
  parameter int CTRL_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alu_upd,
  input  logic [FLAG_BITS-1:0] alu_flags,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [XLEN-1:0]      wr_data,
  input  logic                 rd_sel,
  output logic [XLEN-1:0]      rd_data,
  output logic                 irq_en,
  output logic                 user_mode,
  output logic                 dma_en,
  output logic                 priv_fault
);
  localparam int IRQ_B  = 0;
  localparam int USER_B = 1;
  localparam int DMA_B  = 2;

  logic [FLAG_BITS-1:0] flags_q;
  logic [CTRL_BITS-1:0] ctrl_q;
  logic                 fault_q;

  wire sw_flag = wr_en && !wr_sel;
  wire sw_ctrl = wr_en &&  wr_sel;
  wire blocked = sw_ctrl &&  ctrl_q[USER_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (sw_flag) begin
      flags_q <= wr_data[FLAG_BITS-1:0];
    end else if (alu_upd) begin
      flags_q <= alu_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= blocked;
      if (sw_ctrl && !ctrl_q[USER_B])
        ctrl_q <= wr_data[CTRL_BITS-1:0];
    end
  end

  assign rd_data    = rd_sel ? XLEN'(ctrl_q) : XLEN'(flags_q);
  assign irq_en     = ctrl_q[IRQ_B];
  assign user_mode  = ctrl_q[USER_B];
  assign dma_en     = ctrl_q[DMA_B];
  assign priv_fault = fault_q;
endmodule

module cpu_status_regs_chk #(
  parameter int XLEN      = 32,
  parameter int FLAG_BITS = 4,
  parameter int CTRL_BITS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 alu_upd,
  input logic [FLAG_BITS-1:0] alu_flags,
  input logic                 wr_en,
  input logic                 wr_sel,
  input logic [XLEN-1:0]      wr_data,
  input logic                 rd_sel,
  input logic [XLEN-1:0]      rd_data,
  input logic                 irq_en,
  input logic                 user_mode,
  input logic                 dma_en,
  input logic                 priv_fault,
  input logic [FLAG_BITS-1:0] flags_q
);
  assert_alu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_upd && !(wr_en && !wr_sel)) |=> flags_q == $past(alu_flags));

  assert_sw_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> flags_q == $past(wr_data[FLAG_BITS-1:0]));

  assert_flag_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> rd_data[XLEN-1:FLAG_BITS] == '0);

  assert_ctrl_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> rd_data[XLEN-1:CTRL_BITS] == '0);

  assert_ctrl_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !user_mode) |=>
      {dma_en, user_mode, irq_en} == $past(wr_data[2:0]));

  assert_user_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && user_mode) |=> $stable({dma_en, user_mode, irq_en}));

  assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && user_mode) |=> priv_fault);

  assert_fault_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> $past(wr_en && wr_sel && user_mode));

  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> $stable({dma_en, user_mode, irq_en}));
endmodule

bind cpu_status_regs cpu_status_regs_chk #(
  .XLEN(XLEN), .FLAG_BITS(FLAG_BITS), .CTRL_BITS(CTRL_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .alu_flags(alu_flags),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
  .rd_data(rd_data), .irq_en(irq_en), .user_mode(user_mode),
  .dma_en(dma_en), .priv_fault(priv_fault), .flags_q(flags_q)
);

// File: tb/cpu_status_regs_tb.sv
`timescale 1ns/1ps
module cpu_status_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_upd = 1'b0;
  logic [3:0]  alu_flags = '0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        irq_en, user_mode, dma_en, priv_fault;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    int          req;
    logic [31:0] rd;
    logic [2:0]  ctl;
    logic        flt;
  } item_t;
  item_t sb[$];

  logic [3:0] m_fl = '0;
  logic [2:0] m_cr = '0;

  always #10 clk = ~clk;

  cpu_status_regs u_dut (
    .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .alu_flags(alu_flags),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_en(irq_en), .user_mode(user_mode),
    .dma_en(dma_en), .priv_fault(priv_fault)
  );

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input int req, input logic au, input logic [3:0] af,
                      input logic we, input logic ws, input logic [31:0] wd,
                      input logic rs);
    item_t it;
    logic flt;
    @(negedge clk);
    alu_upd = au; alu_flags = af; wr_en = we; wr_sel = ws;
    wr_data = wd; rd_sel = rs;
    #1;
    check(7, "pre-write read", rd_data, rs ? {29'd0, m_cr} : {28'd0, m_fl}); // R7
    flt = we && ws && m_cr[1];
    if (we && !ws) m_fl = wd[3:0];
    else if (au)   m_fl = af;
    if (we && ws && !m_cr[1]) m_cr = wd[2:0];
    it.req = req;
    it.rd  = rs ? {29'd0, m_cr} : {28'd0, m_fl};
    it.ctl = m_cr;
    it.flt = flt;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(it.req, "rd_data", rd_data, it.rd);
        check(it.req, "ctrl outputs", {29'd0, dma_en, user_mode, irq_en}, {29'd0, it.ctl});
        check(it.req, "priv_fault", {31'd0, priv_fault}, {31'd0, it.flt});
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(1, "flags after reset", rd_data, 32'd0);
    check(1, "ctrl outputs after reset", {28'd0, priv_fault, dma_en, user_mode, irq_en}, 32'd0);
    rd_sel = 1'b1; #1;
    check(1, "control after reset", rd_data, 32'd0);

    step(2, 1'b1, 4'b1011, 1'b0, 1'b0, 32'h0, 1'b0);            // R2 ALU load
    step(3, 1'b0, 4'h0, 1'b1, 1'b0, 32'hFFFF_FFF6, 1'b0);       // R3 reserved flag bits
    step(4, 1'b1, 4'hF, 1'b1, 1'b0, 32'h0000_0009, 1'b0);       // R4 software wins
    step(5, 1'b0, 4'h0, 1'b1, 1'b1, 32'hFFFF_FFFD, 1'b1);       // R5 irq+dma, reserved
    step(8, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0, 1'b0);               // R8 flags untouched
    step(5, 1'b0, 4'h0, 1'b1, 1'b1, 32'h0000_0006, 1'b1);       // R5 enter user mode
    step(6, 1'b0, 4'h0, 1'b1, 1'b1, 32'h0000_0001, 1'b1);       // R6 dropped, fault
    step(9, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0, 1'b1);               // R9 fault gone
    step(6, 1'b0, 4'h0, 1'b1, 1'b1, 32'h0000_0000, 1'b1);       // R6 again
    step(6, 1'b0, 4'h0, 1'b1, 1'b1, 32'h0000_0005, 1'b1);       // R6 back to back
    step(9, 1'b0, 4'h0, 1'b1, 1'b0, 32'h0000_0003, 1'b0);       // R9 user flag write
    step(8, 1'b1, 4'hC, 1'b0, 1'b0, 32'h0, 1'b1);               // R8 ALU leaves ctrl
    step(2, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0, 1'b0);               // R2 flags now C
    step(9, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0, 1'b1);
    repeat (3) @(posedge clk);
    #5;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule